// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (clock line SCL, open-drain data line SDA) that holds a small file of control registers for a clock generator. A system clock several times faster than SCL oversamples both lines. Start, stop and bit timing are recovered from the sampled edges. The slave answers a single 7-bit device address and supports four transaction kinds: byte write, byte read, block write and block read. The master always sends a command code after the address. Bit 7 of the command code picks byte access (1) or block access (0), and bits 6:0 give the starting register index.

A block write carries a byte count before its data bytes. A block read returns a byte count, taken from the count register, before the data bytes. Block data moves through consecutive registers from the named index upward, MSB first. The master may end any transfer after a complete byte. The register contents drive the output-enable, identification and amplitude controls of the clock path.

Top module: `ctrl_twi_regslave`

## Requirements
- R1: After reset the six registers, indices 0 to 5, hold 04h, 00h, C0h, 08h, 06h and D8h.
- R2: The slave drives an ACK (SDA low in the ninth clock) only for address byte D6h (7-bit address 6Bh, write) or D7h (read). For any other address it pulls SDA for no bit until the next START.
- R3: Command code bit 7 = 1 selects byte mode, in which exactly one data byte is accepted and a second data byte is NACKed and not stored. Bit 7 = 0 selects block mode. Bits 6:0 are the register index.
- R4: A byte write stores the data byte, reserved bits included, into the indexed register. No register changes without an accepted data byte.
- R5: A byte read (command, repeated START, address D7h) returns the indexed register MSB first.
- R6: A block write ACKs the count byte and then stores each data byte into consecutive registers starting at the command's index.
- R7: In a block write, data bytes beyond the announced count are NACKed and not stored.
- R8: A block read first returns the contents of register 4 as the byte count. It then returns registers from the command's index upward while the master ACKs, and ends when the master NACKs.
- R9: Indices 6 and above are acknowledged. Writes to them change no register, and reads of them return 00h.
- R10: A STOP at any bit position returns the slave to idle with SDA released. Bytes already accepted in the interrupted transfer stay stored.
- R11: The field outputs are wired as follows: reference enable is register 0 bit 2; differential enable 0 is register 2 bit 7; differential enable 1 is register 2 bit 6; identification is register 3; byte count is register 4; amplitude select is register 5 bit 7; amplitude code is register 5 bits 6:4.
- R12: The SDA pull-down changes only in response to a falling SCL edge, a START or a STOP, never in the middle of an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| regs_o | output | NREG*8 | All registers, index i at bits i*8+7:i*8 |
| ref_en_o | output | 1 | Reference clock output enable |
| diff_en_o | output | 2 | Differential output enables, bit n for output n |
| ident_o | output | 8 | Revision and vendor identification byte |
| bcount_o | output | 8 | Byte count returned on block reads |
| amp_sel_o | output | 1 | 1 selects the programmed amplitude |
| amp_code_o | output | 3 | Amplitude step code |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except at START and STOP, and each SCL level lasts longer than the synchroniser latency. Reset is also assumed low from the first clock edge. The bench master meets these conditions: it changes SDA a quarter bit period after SCL falls, holds every SCL level for ten system clocks, and keeps reset low from time zero. A bench monitor also confirms that the slave's pull-down never moves while SCL is high.

// File: rtl/twi_pkg.sv
// Shared types and register defaults for the two-wire control slave.
// Assumes 8-bit registers; register indices that other logic decodes live here.
package twi_pkg;
    localparam int REG_W     = 8;
    localparam int IDX_REF   = 0;
    localparam int IDX_OUTEN = 2;
    localparam int IDX_IDENT = 3;
    localparam int IDX_CNT   = 4;
    localparam int IDX_AMP   = 5;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK, PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        FLD_ADDR, FLD_CMD, FLD_CNT, FLD_DATA
    } field_t;

    // Power-up value of register idx
    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h04;
            2:       return 8'hC0;
            3:       return 8'h08;
            4:       return 8'h06;
            5:       return 8'hD8;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/twi_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and flags
// SCL edges plus START/STOP conditions.
// Assumes each SCL level lasts several system clocks.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;
    logic              scl_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Shift the raw lines through the synchroniser; idle bus reads high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    // Edge and bus-condition decode from current and previous samples
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twi_regfile.sv
// Control register file with per-register reset values.
// Writes to an index at or above NREG are dropped; reads there give 00h.
module twi_regfile
    import twi_pkg::*;
#(
    parameter int NREG = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_idx,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [REG_W-1:0]      rd_idx,
    output logic [REG_W-1:0]      rd_data,
    output logic [NREG*REG_W-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [REG_W-1:0] r;
        // Hold one register; load its default on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= reg_default(g);
            else if (wr_en && wr_idx == REG_W'(g))
                r <= wr_data;
        end
        assign regs_flat[g*REG_W +: REG_W] = r;
    end

    // Read multiplexer, zero outside the populated range
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == REG_W'(i))
                rd_data = regs_flat[i*REG_W +: REG_W];
    end
endmodule

// File: rtl/twi_xfer_fsm.sv
// Transaction engine: address match, command decode, byte/block write
// and read sequencing, ACK generation and bit serialisation.
// Assumes edge and START/STOP flags from twi_line_sync.
module twi_xfer_fsm
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             sda_s,
    input  logic [REG_W-1:0] rd_data,
    input  logic [REG_W-1:0] cnt_byte,
    output logic [REG_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data,
    output logic             sda_pull
);
    phase_t           phase;
    field_t           field;
    logic [3:0]       bitcnt;
    logic [REG_W-1:0] shreg, txsh, ptr, rem;
    logic             byte_mode, goto_tx, cnt_pending;
    logic [REG_W-1:0] tx_next;

    assign rd_idx = ptr;

    // Next byte to transmit: count first on block reads, then register data
    always_comb tx_next = cnt_pending ? cnt_byte : rd_data;

    // Bus sequencing, one step per detected bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            field       <= FLD_ADDR;
            bitcnt      <= '0;
            shreg       <= '0;
            txsh        <= '0;
            ptr         <= '0;
            rem         <= '0;
            byte_mode   <= 1'b0;
            goto_tx     <= 1'b0;
            cnt_pending <= 1'b0;
            wr_en       <= 1'b0;
            wr_idx      <= '0;
            wr_data     <= '0;
            sda_pull    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_evt) begin
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
            end else if (start_evt) begin
                phase    <= PH_RX;
                field    <= FLD_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[REG_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (field)
                                FLD_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        sda_pull    <= 1'b1;
                                        phase       <= PH_RXACK;
                                        goto_tx     <= shreg[0];
                                        cnt_pending <= shreg[0] & ~byte_mode;
                                        field       <= FLD_CMD;
                                    end else begin
                                        phase <= PH_SKIP;
                                    end
                                end
                                FLD_CMD: begin
                                    sda_pull  <= 1'b1;
                                    phase     <= PH_RXACK;
                                    ptr       <= {1'b0, shreg[6:0]};
                                    byte_mode <= shreg[7];
                                    rem       <= 8'd1;
                                    field     <= shreg[7] ? FLD_DATA : FLD_CNT;
                                end
                                FLD_CNT: begin
                                    sda_pull <= 1'b1;
                                    phase    <= PH_RXACK;
                                    rem      <= shreg;
                                    field    <= FLD_DATA;
                                end
                                default: begin
                                    if (rem != '0) begin
                                        sda_pull <= 1'b1;
                                        phase    <= PH_RXACK;
                                        wr_en    <= 1'b1;
                                        wr_idx   <= ptr;
                                        wr_data  <= shreg;
                                        ptr      <= ptr + 8'd1;
                                        rem      <= rem - 8'd1;
                                    end else begin
                                        phase <= PH_SKIP;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_RXACK: begin
                        if (scl_fall) begin
                            if (goto_tx) begin
                                txsh     <= tx_next;
                                bitcnt   <= '0;
                                sda_pull <= ~tx_next[7];
                                phase    <= PH_TX;
                                if (cnt_pending) cnt_pending <= 1'b0;
                                else             ptr <= ptr + 8'd1;
                            end else begin
                                sda_pull <= 1'b0;
                                phase    <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                phase    <= PH_TXACK;
                            end else begin
                                txsh     <= {txsh[REG_W-2:0], 1'b0};
                                sda_pull <= ~txsh[6];
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    PH_TXACK: begin
                        if (scl_rise && sda_s) begin
                            phase <= PH_SKIP;
                        end else if (scl_fall) begin
                            txsh     <= tx_next;
                            bitcnt   <= '0;
                            sda_pull <= ~tx_next[7];
                            phase    <= PH_TX;
                            if (cnt_pending) cnt_pending <= 1'b0;
                            else             ptr <= ptr + 8'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctrl_twi_regslave.sv
// Top level: two-wire control slave with its register file and the
// decoded control fields. Assumes SCL at most about a tenth of clk.
module ctrl_twi_regslave
    import twi_pkg::*;
#(
    parameter int         NREG        = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h6B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NREG*REG_W-1:0] regs_o,
    output logic                  ref_en_o,
    output logic [1:0]            diff_en_o,
    output logic [REG_W-1:0]      ident_o,
    output logic [REG_W-1:0]      bcount_o,
    output logic                  amp_sel_o,
    output logic [2:0]            amp_code_o
);
    logic             sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic             wr_en;
    logic [REG_W-1:0] wr_idx, wr_data, rd_idx, rd_data;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
        .rd_data(rd_data), .cnt_byte(bcount_o), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_pull(sda_pull_o)
    );

    twi_regfile #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .regs_flat(regs_o)
    );

    // Decode control fields from the register image
    always_comb begin
        ref_en_o     = regs_o[IDX_REF*REG_W + 2];
        diff_en_o[0] = regs_o[IDX_OUTEN*REG_W + 7];
        diff_en_o[1] = regs_o[IDX_OUTEN*REG_W + 6];
        ident_o      = regs_o[IDX_IDENT*REG_W +: REG_W];
        bcount_o     = regs_o[IDX_CNT*REG_W +: REG_W];
        amp_sel_o    = regs_o[IDX_AMP*REG_W + 7];
        amp_code_o   = regs_o[IDX_AMP*REG_W + 4 +: 3];
    end
endmodule

// File: rtl/ctrl_twi_regslave_chk.sv
// Property checker for ctrl_twi_regslave, attached by bind.
// Assumes reset is low at the first clock edge.
module twi_regslave_chk
    import twi_pkg::*;
#(
    parameter int NREG = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_pull_o,
    input logic [NREG*REG_W-1:0] regs_o,
    input logic                  wr_en,
    input logic [REG_W-1:0]      wr_idx,
    input logic                  scl_fall,
    input logic                  start_evt,
    input logic                  stop_evt
);
    function automatic logic [NREG*REG_W-1:0] reset_image();
        logic [NREG*REG_W-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*REG_W +: REG_W] = reg_default(i);
        return v;
    endfunction
    localparam logic [NREG*REG_W-1:0] RST_IMG = reset_image();

    // R1
    reset_image_chk: assert property (@(posedge clk)
        !rst_n |=> regs_o == RST_IMG);

    // R9
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= REG_W'(NREG)) |=> $stable(regs_o));

    // R4
    quiet_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o);

    // R12
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));
endmodule

bind ctrl_twi_regslave twi_regslave_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .regs_o(regs_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/sim_ctrl_twi_regslave.sv
// Scoreboard bench: bus master tasks push expected items, a monitor pops
// and compares them against what the slave produced.
module sim_ctrl_twi_regslave;
    localparam int CLK_P = 10;
    localparam int Q     = 5;
    localparam int NREG  = 6;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull, sda_line;
    logic [NREG*8-1:0] regs;
    logic ref_en, amp_sel;
    logic [1:0] diff_en;
    logic [7:0] ident, bcount;
    logic [2:0] amp_code;

    logic [63:0] exp_q[$], obs_q[$];
    string       tag_q[$];
    int n_chk = 0, n_fail = 0, r12_bad = 0;
    logic prev_scl = 1'b1, prev_pull = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    ctrl_twi_regslave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .regs_o(regs), .ref_en_o(ref_en),
        .diff_en_o(diff_en), .ident_o(ident), .bcount_o(bcount),
        .amp_sel_o(amp_sel), .amp_code_o(amp_code)
    );

    task automatic push_exp(logic [63:0] v, string t);
        exp_q.push_back(v); tag_q.push_back(t);
    endtask
    task automatic check_port(logic [63:0] act, logic [63:0] e, string t);
        push_exp(e, t); obs_q.push_back(act);
    endtask
    task automatic q_wait(); #(Q*CLK_P); endtask
    task automatic bus_start();
        sda_m = 1; q_wait(); scl_m = 1; q_wait(); sda_m = 0; q_wait(); scl_m = 0; q_wait();
    endtask
    task automatic bus_stop();
        sda_m = 0; q_wait(); scl_m = 1; q_wait(); sda_m = 1; q_wait(); q_wait();
    endtask
    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; q_wait(); scl_m = 1; q_wait(); q_wait(); scl_m = 0; q_wait();
        end
    endtask
    // Send a byte; expect ack bit value (0 = ACK)
    task automatic tx(logic [7:0] b, logic exp_bit, string t);
        logic got;
        send_bits(b, 8);
        sda_m = 1; q_wait(); scl_m = 1; q_wait(); got = sda_line; q_wait(); scl_m = 0; q_wait();
        push_exp(64'(exp_bit), t); obs_q.push_back(64'(got));
    endtask
    // Receive a byte and answer with ACK (m_ack=1) or NACK
    task automatic rx(logic m_ack, logic [7:0] e, string t);
        logic [7:0] got;
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            q_wait(); scl_m = 1; q_wait(); got[i] = sda_line; q_wait(); scl_m = 0; q_wait();
        end
        sda_m = ~m_ack; q_wait(); scl_m = 1; q_wait(); q_wait(); scl_m = 0; q_wait(); sda_m = 1;
        push_exp(64'(e), t); obs_q.push_back(64'(got));
    endtask
    task automatic byte_write(logic [7:0] cmd, logic [7:0] d, string t);
        bus_start(); tx(8'hD6, 0, t); tx(cmd, 0, t); tx(d, 0, t); bus_stop();
    endtask
    task automatic byte_read(logic [7:0] cmd, logic [7:0] e, string t);
        bus_start(); tx(8'hD6, 0, t); tx(cmd, 0, t);
        bus_start(); tx(8'hD7, 0, t); rx(0, e, t); bus_stop();
    endtask
    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: pair each observation with the oldest expectation
    initial forever begin
        @(negedge clk);
        while (obs_q.size() > 0) begin
            logic [63:0] o, e;
            string t;
            o = obs_q.pop_front();
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unmatched: actual %0h expected none", o);
            end else begin
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if (o !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %0h expected %0h", t, o, e);
                end
            end
        end
    end

    // R12: pull-down must hold still while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_pull !== prev_pull)) r12_bad++;
        prev_scl  = scl_m;
        prev_pull = sda_pull;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 reset image, R11 field wiring
        check_port(64'(regs), 64'hD8_06_08_C0_00_04, "R1");
        check_port(64'({ref_en, diff_en, ident, bcount, amp_sel, amp_code}),
                   64'({1'b1, 2'b11, 8'h08, 8'h06, 1'b1, 3'b101}), "R11");
        check_port(64'(sda_pull), 0, "R1");

        // R4 byte write clears reference enable
        byte_write(8'h80, 8'h00, "R4");
        check_port(64'(regs[7:0]), 64'h00, "R4");
        check_port(64'(ref_en), 0, "R11");

        // R4 reserved bits kept, R5 byte read back
        byte_write(8'h82, 8'h7F, "R4");
        check_port(64'(diff_en), 64'b10, "R11");
        byte_read(8'h82, 8'h7F, "R5");

        // R2 foreign address: no ACK on address or following byte
        bus_start(); tx(8'hA0, 1, "R2"); tx(8'h00, 1, "R2"); bus_stop();
        check_port(64'(regs[23:16]), 64'h7F, "R2");

        // R3 byte mode takes exactly one data byte
        bus_start(); tx(8'hD6, 0, "R3"); tx(8'h83, 0, "R3");
        tx(8'h11, 0, "R3"); tx(8'h22, 1, "R3"); bus_stop();
        check_port(64'(regs[39:24]), 64'h06_11, "R3");

        // R6 block write of three bytes, R7 fourth byte refused
        bus_start(); tx(8'hD6, 0, "R6"); tx(8'h01, 0, "R6"); tx(8'h03, 0, "R6");
        tx(8'hA1, 0, "R6"); tx(8'hB2, 0, "R6"); tx(8'hC3, 0, "R6");
        tx(8'h5A, 1, "R7"); bus_stop();
        check_port(64'(regs[39:8]), 64'h06_C3_B2_A1, "R7");

        // R8 block read: count then data upward, NACK ends it
        bus_start(); tx(8'hD6, 0, "R8"); tx(8'h01, 0, "R8");
        bus_start(); tx(8'hD7, 0, "R8");
        rx(1, 8'h06, "R8"); rx(1, 8'hA1, "R8"); rx(1, 8'hB2, "R8");
        rx(1, 8'hC3, "R8"); rx(0, 8'h06, "R8"); bus_stop();

        // R9 index beyond the file
        byte_write(8'h86, 8'h55, "R9");
        check_port(64'(regs), 64'hD8_06_C3_B2_A1_00, "R9");
        byte_read(8'h86, 8'h00, "R9");
        bus_start(); tx(8'hD6, 0, "R9"); tx(8'h05, 0, "R9");
        bus_start(); tx(8'hD7, 0, "R9");
        rx(1, 8'h06, "R9"); rx(1, 8'hD8, "R9"); rx(0, 8'h00, "R9"); bus_stop();

        // R10 interrupted block write keeps the accepted byte
        bus_start(); tx(8'hD6, 0, "R10"); tx(8'h05, 0, "R10"); tx(8'h02, 0, "R10");
        tx(8'h40, 0, "R10"); bus_stop();
        check_port(64'(regs[47:40]), 64'h40, "R10");
        check_port(64'({amp_sel, amp_code}), 64'({1'b0, 3'b100}), "R11");
        // R10 STOP in mid byte, then a clean transfer
        bus_start(); send_bits(8'hD6, 4); bus_stop();
        check_port(64'(sda_pull), 0, "R10");
        byte_read(8'h85, 8'h40, "R10");

        check_port(64'(r12_bad), 0, "R12");
        repeat (10) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL drain: actual %0d expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule